// File: doc/BRIEF.md
# Real-Time Clock Update Cycle Sequencer

This block paces the once-per-second update of a real-time clock running from a 32.768 kHz reference. A free-running prescaler divides the reference by a power of two. Each time it wraps, an update window opens. The block first raises the update-in-progress status and holds it for a short lead interval. It then issues a single-cycle advance strobe to an external calendar counter and keeps the status high through the whole busy interval. When the window completes, the status drops and a one-cycle completion pulse is produced. Because the status is raised ahead of the busy interval and kept high until the interval is over, software may read the time registers safely at any moment it sees the status low.

Two control inputs stop updates. The time-set hold is used while software writes the time: it forces the status low in the same cycle, cancels a running or pending window, and suppresses the completion pulse. The divider-reset input holds the prescaler at zero, so no windows occur until it is released.

A separate flag reports whether RAM and time contents are valid. It is set by reset and cleared by a power-fail indication.

Top module: `rtc_update_seq`

## Requirements
- R1: With the prescaler width W, an update window opens every 2^W reference cycles. The first window after reset or divider release starts with the update-in-progress output high in the 2^W-th cycle after the cycle in which the prescaler was last cleared.
- R2: The update-in-progress output is high for exactly LEAD_CYC cycles before the advance strobe.
- R3: In an uninterrupted window, update-in-progress stays high for exactly LEAD_CYC + UPD_CYC consecutive cycles and is otherwise low.
- R4: The advance strobe is high for exactly one cycle per uninterrupted window. That cycle is the first cycle of the busy interval, offset LEAD_CYC from the rise of update-in-progress.
- R5: The update-done output is a one-cycle pulse in the first cycle in which update-in-progress is low after an uninterrupted window.
- R6: While the time-set hold is 1, update-in-progress and the advance strobe are 0 in that same cycle. A window interrupted by the hold is abandoned and produces no update-done pulse.
- R7: A prescaler wrap seen while the time-set hold is 1 opens no window, but the prescaler keeps counting, so later windows keep their original phase.
- R8: While divider reset is 1, the prescaler is held at zero, any window is abandoned and no window opens.
- R9: The valid flag becomes 0 in the cycle after power-fail is seen high and remains 0 until reset.
- R10: During and right after reset, update-in-progress, advance and update-done are 0 and the valid flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst | input | 1 | synchronous active-high reset |
| set_hold | input | 1 | time-set hold, blocks and cancels updates |
| div_reset | input | 1 | holds the prescaler at zero |
| power_fail | input | 1 | clears the valid flag |
| uip_o | output | 1 | update-in-progress status |
| advance_o | output | 1 | one-cycle advance-time strobe to the calendar |
| update_done_o | output | 1 | one-cycle update-ended pulse |
| valid_o | output | 1 | RAM and time valid status |

## Verification
The bench builds the block with PRESCALE_W = 6, LEAD_CYC = 3 and UPD_CYC = 5, giving a 64-cycle period instead of 32768. This brings dozens of complete windows within reach. It also makes it cheap to place a time-set hold across a prescaler wrap, in the middle of a lead or busy interval, and just before completion, and to release the divider reset many times. The short lead and busy lengths still keep the two intervals distinct, so an off-by-one in either shows up as a shifted strobe or a wrong window length.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_BUSY = 2'd2
    } phase_e;

    typedef struct packed {
        logic uip;
        logic advance;
        logic done;
    } seq_out_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned PRESCALE_W = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic div_reset,
    output logic wrap_o
);
    localparam logic [PRESCALE_W-1:0] LAST = '1;

    logic [PRESCALE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || div_reset) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wrap_o = (cnt_q == LAST) && !div_reset;

    // R8: a held divider leaves the prescaler at zero
    assert_hold_zero_R8: assert property (@(posedge clk) disable iff (rst)
        div_reset |=> (cnt_q == '0));

    // R1: counting resumes from zero and never wraps within one cycle of a clear
    assert_no_early_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        div_reset |=> !wrap_o || div_reset);

endmodule

// File: rtl/rtc_window_fsm.sv
module rtc_window_fsm
    import rtc_seq_pkg::*;
#(
    parameter int unsigned LEAD_CYC = 8,
    parameter int unsigned UPD_CYC  = 65
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wrap_i,
    input  logic     abort_i,
    output seq_out_t out_o
);
    localparam int unsigned PH_W = cnt_width(max_u(LEAD_CYC, UPD_CYC));
    localparam logic [PH_W-1:0] LEAD_LAST = PH_W'(LEAD_CYC - 1);
    localparam logic [PH_W-1:0] BUSY_LAST = PH_W'(UPD_CYC - 1);

    phase_e          state_q;
    logic [PH_W-1:0] ph_q;
    logic            done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            ph_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort_i) begin
                state_q <= PH_IDLE;
                ph_q    <= '0;
            end else begin
                unique case (state_q)
                    PH_IDLE: begin
                        ph_q <= '0;
                        if (wrap_i) state_q <= PH_LEAD;
                    end
                    PH_LEAD: begin
                        if (ph_q == LEAD_LAST) begin
                            state_q <= PH_BUSY;
                            ph_q    <= '0;
                        end else begin
                            ph_q <= ph_q + 1'b1;
                        end
                    end
                    PH_BUSY: begin
                        if (ph_q == BUSY_LAST) begin
                            state_q <= PH_IDLE;
                            ph_q    <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            ph_q <= ph_q + 1'b1;
                        end
                    end
                    default: begin
                        state_q <= PH_IDLE;
                        ph_q    <= '0;
                    end
                endcase
            end
        end
    end

    always_comb begin
        out_o.uip     = (state_q != PH_IDLE) && !abort_i;
        out_o.advance = (state_q == PH_BUSY) && (ph_q == '0) && !abort_i;
        out_o.done    = done_q;
    end

    // R4: the advance strobe never lasts two cycles
    assert_adv_single_R4: assert property (@(posedge clk) disable iff (rst)
        out_o.advance |=> !out_o.advance);

    // R5: completion pulse only right after a busy interval, with the status low
    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !out_o.uip && $past(state_q == PH_BUSY));

    // R6: an abort never leads to a completion pulse
    assert_abort_no_done_R6: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !done_q);

endmodule

// File: rtl/rtc_valid_flag.sv
module rtc_valid_flag (
    input  logic clk,
    input  logic rst,
    input  logic power_fail,
    output logic valid_o
);
    logic valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b1;
        end else if (power_fail) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;

    // R9: power-fail clears the flag in the next cycle
    assert_pf_clears_R9: assert property (@(posedge clk) disable iff (rst)
        power_fail |=> !valid_q);

    // R9: once cleared, only reset restores it
    assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_q |=> !valid_q);

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
    import rtc_seq_pkg::*;
#(
    parameter int unsigned PRESCALE_W = 15,
    parameter int unsigned LEAD_CYC   = 8,
    parameter int unsigned UPD_CYC    = 65
) (
    input  logic clk,
    input  logic rst,
    input  logic set_hold,
    input  logic div_reset,
    input  logic power_fail,
    output logic uip_o,
    output logic advance_o,
    output logic update_done_o,
    output logic valid_o
);
    localparam int unsigned PERIOD = 1 << PRESCALE_W;
    localparam int unsigned WINDOW = LEAD_CYC + UPD_CYC;

    logic     wrap;
    logic     abort;
    seq_out_t seq;

    assign abort = set_hold | div_reset;

    rtc_prescaler #(.PRESCALE_W(PRESCALE_W)) u_prescaler (
        .clk       (clk),
        .rst       (rst),
        .div_reset (div_reset),
        .wrap_o    (wrap)
    );

    rtc_window_fsm #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) u_window (
        .clk     (clk),
        .rst     (rst),
        .wrap_i  (wrap),
        .abort_i (abort),
        .out_o   (seq)
    );

    rtc_valid_flag u_valid (
        .clk        (clk),
        .rst        (rst),
        .power_fail (power_fail),
        .valid_o    (valid_o)
    );

    assign uip_o         = seq.uip;
    assign advance_o     = seq.advance;
    assign update_done_o = seq.done;

    initial begin
        assert_params_R3: assert (LEAD_CYC >= 1 && UPD_CYC >= 1 && WINDOW < PERIOD)
            else $error("window must fit inside one prescaler period");
    end

    // R2: the strobe is always preceded by a status that was already high
    assert_lead_before_adv_R2: assert property (@(posedge clk) disable iff (rst)
        advance_o |-> $past(uip_o));

endmodule

// File: tb/rtc_update_seq_bench.sv
module rtc_update_seq_bench;
    localparam int W = 6;
    localparam int L = 3;
    localparam int U = 5;
    localparam int P = 1 << W;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1, set_hold = 1'b0, div_reset = 1'b0, power_fail = 1'b0;
    logic uip, adv, done, vrt;

    rtc_update_seq #(.PRESCALE_W(W), .LEAD_CYC(L), .UPD_CYC(U)) u_rtc_update_seq (
        .clk(clk), .rst(rst), .set_hold(set_hold), .div_reset(div_reset),
        .power_fail(power_fail), .uip_o(uip), .advance_o(adv),
        .update_done_o(done), .valid_o(vrt)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        bit act;
        int pos;
        bit dn;
        bit ok;
    } exp_t;
    exp_t q[$];

    bit m_act = 0, m_done = 0, m_vrt = 1;
    int m_pos = 0;

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // driver-side model: pushes the expected state for the cycle after each edge
    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_act = 0; m_done = 0; m_vrt = 1;
        end else begin
            m_done = m_act && (m_pos == L + U - 1) && !set_hold && !div_reset;
            if (div_reset) begin
                m_pos = 0; m_act = 0;
            end else if (m_pos == P - 1) begin
                m_pos = 0; m_act = !set_hold;
            end else begin
                m_act = m_act && !set_hold && (m_pos + 1 < L + U);
                m_pos = m_pos + 1;
            end
            if (power_fail) m_vrt = 0;
        end
        q.push_back('{m_act, m_pos, m_done, m_vrt});
    end

    // monitor: compares each cycle's outputs against the queued expectation
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            bit eu;
            e  = q.pop_front();
            eu = e.act && !set_hold && !div_reset;
            check("R3 uip window", uip, eu);
            check("R4 advance strobe", adv, eu && (e.pos == L));
            check("R5 update done", done, e.dn);
            check("R9 valid flag", vrt, e.ok);
            if (set_hold)  check("R6 uip low under hold", uip, 1'b0);
            if (div_reset) check("R8 uip low under divider reset", uip, 1'b0);
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (uip !== 1'b1 && n < 4 * P);
    endtask

    initial begin
        int n, r, hi, gap;
        step(3);
        @(negedge clk);
        check("R10 reset uip", uip, 1'b0);
        check("R10 reset advance", adv, 1'b0);
        check("R10 reset done", done, 1'b0);
        check("R10 reset valid", vrt, 1'b1);
        @(posedge clk); #1 rst = 1'b0;

        wait_rise(n);
        check_int("R1 first window after reset", n, P + 1);
        r = 0;
        while (adv !== 1'b1 && r < P) begin @(negedge clk); r++; end
        check_int("R2 lead before advance", r, L);
        hi = r;
        while (uip === 1'b1 && hi < P) begin @(negedge clk); hi++; end
        check_int("R3 window length", hi, L + U);
        check("R5 done at fall", done, 1'b1);
        @(negedge clk);
        check("R5 done one cycle", done, 1'b0);
        gap = 1;
        while (uip !== 1'b1 && gap < 2 * P) begin @(negedge clk); gap++; end
        check_int("R1 period", gap + L + U, P);

        // hold in the middle of the busy interval
        step(L + 1);
        set_hold = 1'b1;
        @(negedge clk);
        check("R6 uip drops at once", uip, 1'b0);
        step(1);
        set_hold = 1'b0;
        n = 0;
        repeat (20) begin @(negedge clk); if (done === 1'b1) n++; end
        check_int("R6 no done after cancel", n, 0);

        // hold across a wrap: no window, phase kept
        step(P - 30);
        set_hold = 1'b1;
        n = 0;
        repeat (P + 10) begin @(negedge clk); if (uip === 1'b1) n++; end
        check_int("R7 no window while held", n, 0);
        @(posedge clk); #1 set_hold = 1'b0;
        step(2 * P);

        // divider reset
        div_reset = 1'b1;
        n = 0;
        repeat (3 * P) begin @(negedge clk); if (uip === 1'b1 || adv === 1'b1) n++; end
        check_int("R8 no activity under divider reset", n, 0);
        @(posedge clk); #1 div_reset = 1'b0;
        wait_rise(n);
        check_int("R8 first window after release", n, P + 1);
        step(P);

        // power fail
        power_fail = 1'b1;
        step(1);
        power_fail = 1'b0;
        @(negedge clk);
        check("R9 valid cleared", vrt, 1'b0);
        step(10);
        @(negedge clk);
        check("R9 valid stays clear", vrt, 1'b0);
        @(posedge clk); #1 rst = 1'b1;
        step(2);
        @(negedge clk);
        check("R10 valid restored by reset", vrt, 1'b1);
        @(posedge clk); #1 rst = 1'b0;
        step(3 * P);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule